// File: doc/BRIEF.md
# Programmable Oversampling Bit-Rate Generator

This block produces the bit timing for a serial receiver and transmitter of the classic 16550 kind. It adds a speed-mode register that changes how many oversampling ticks make up one bit. A small byte-wide register port holds a 16-bit divisor, the line-control byte whose top bit opens the divisor latch, the speed mode, a programmable tick count, a programmable capture point and a rate-fix control. From these the block derives an oversampling tick every `divisor` input clocks. It also derives a bit boundary every `ratio` oversampling ticks, where the ratio is 16, 4, or the programmed count plus one. Finally it raises a capture strobe on one chosen tick inside each bit, and the receive line is latched into a single output bit on that strobe.

The receive input passes through a two-flop synchronizer. While the block is hunting for a start bit, a falling edge on the line restarts both counters so that the capture point falls inside the bit rather than on an edge. A new configuration is copied into the working set only at a bit boundary, at a start-bit restart, or while the working divisor is zero. A period that has already started therefore always finishes with the settings it began with.

Top module: `uart_rate_gen`

## Requirements
- R1: After reset the divisor is 0, the line-control byte is 0x00, the speed mode is 0, the tick count is 0x00, the capture point is 0xFF and the rate-fix value is 0. No tick, boundary or strobe appears until a divisor is programmed.
- R2: A register is selected by its word number shifted left by two bits. The word numbers are: line control 3, speed mode 9, tick count 10 (0x0A), capture point 11 (0x0B) and rate fix 13 (0x0D). A read returns the value on `rdata` one clock after `rd_en`. An access whose two low address bits are not zero is ignored.
- R3: The divisor low byte (word 0) and high byte (word 1) can be written and read only while bit 7 of the line-control byte is 1. Otherwise writes to those words are dropped and reads of them return 0.
- R4: `os_tick` pulses once every `divisor` clocks. A divisor of 0 stops all tick generation.
- R5: In speed modes 0 and 1, a bit lasts 16 oversampling ticks, which is 16 × divisor clocks.
- R6: In speed mode 2, a bit lasts 4 × divisor clocks.
- R7: In speed mode 3, a bit lasts (count + 1) × divisor clocks. This holds down to count 0 (one tick per bit) and up to count 255 (256 ticks).
- R8: The capture strobe fires on tick index p of each bit, counting from 0, so it comes (p + 1) × divisor clocks after the preceding boundary. In mode 3, p is the capture-point value when that value is not 0xFF and is below the ratio. In every other case p = (ratio − 2) >> 1, or 0 when the ratio is 1.
- R9: `sample_bit` takes the synchronized receive level on each strobe and holds it between strobes.
- R10: While hunting, a falling receive edge restarts the timing. The first strobe then appears 3 + (p + 1) × divisor clock edges after the input changes, and the first boundary appears 3 + ratio × divisor edges after it. Hunting is active after reset and after any strobe that sees a high level. A falling edge while not hunting has no effect.
- R11: A write to the divisor, mode, count or capture-point register does not alter the bit period in progress. The new value governs the period that starts at the next boundary.
- R12: The rate-fix register stores its bit 0 and reads it back. Its value has no effect on the timing.
- R13: `bit_tick` and `sample_strobe` are one-clock pulses that occur only together with an `os_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (6) | Byte address, word number in bits [ADDR_W-1:2] |
| wdata | input | DATA_W (8) | Write data |
| rdata | output | DATA_W (8) | Registered read data |
| rx_in | input | 1 | Asynchronous receive line |
| os_tick | output | 1 | Oversampling tick pulse |
| bit_tick | output | 1 | Bit boundary pulse |
| sample_strobe | output | 1 | Capture pulse |
| sample_bit | output | 1 | Receive level captured at the last strobe |

## Verification
Read data is due one edge after the read strobe, so the bench samples `rdata` at the falling clock edge that follows that edge. Periods and capture offsets are measured as counts of falling edges between registered `bit_tick` pulses, which makes each check independent of the pipeline latency. Each measurement starts only after two boundaries have passed since the configuration was written, and the mid-period write test drives its write three edges into a measured period so that it can prove the old period is still in force. The start-bit test counts edges from the falling-edge drive and expects the strobe and the boundary exactly 3 + (p + 1) × divisor and 3 + ratio × divisor edges later, which accounts for two synchronizer flops, the edge-detect flop and the output register.

// File: rtl/uart_rate_pkg.sv
package uart_rate_pkg;

  // word numbers of the register port (byte address = word << 2)
  localparam int OFS_DIV_LO  = 0;
  localparam int OFS_DIV_HI  = 1;
  localparam int OFS_LINE    = 3;
  localparam int OFS_SPEED   = 9;
  localparam int OFS_COUNT   = 10;
  localparam int OFS_POINT   = 11;
  localparam int OFS_FIX     = 13;

  // line-control bit that opens the divisor latch
  localparam int LATCH_OPEN_BIT = 7;

  typedef enum logic [1:0] {
    SPD_STD     = 2'd0,
    SPD_STD_ALT = 2'd1,
    SPD_QUAD    = 2'd2,
    SPD_PROG    = 2'd3
  } speed_mode_e;

endpackage

// File: rtl/urg_regs.sv
module urg_regs
  import uart_rate_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  output logic [2*DATA_W-1:0]   divisor,
  output logic [1:0]            speed,
  output logic [DATA_W-1:0]     count,
  output logic [DATA_W-1:0]     point
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic [DATA_W-1:0] line_ctl;
  logic              fix_bit;
  logic              latch_open;

  assign word       = addr[ADDR_W-1:2];
  assign aligned    = (addr[1:0] == 2'b00);
  assign latch_open = line_ctl[LATCH_OPEN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      divisor  <= '0;
      line_ctl <= '0;
      speed    <= '0;
      count    <= '0;
      point    <= '1;
      fix_bit  <= 1'b0;
    end else if (wr_en && aligned) begin
      case (word)
        WORD_W'(OFS_DIV_LO): if (latch_open) divisor[DATA_W-1:0]        <= wdata;
        WORD_W'(OFS_DIV_HI): if (latch_open) divisor[2*DATA_W-1:DATA_W] <= wdata;
        WORD_W'(OFS_LINE):   line_ctl <= wdata;
        WORD_W'(OFS_SPEED):  speed    <= wdata[1:0];
        WORD_W'(OFS_COUNT):  count    <= wdata;
        WORD_W'(OFS_POINT):  point    <= wdata;
        WORD_W'(OFS_FIX):    fix_bit  <= wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= '0;
      if (aligned) begin
        case (word)
          WORD_W'(OFS_DIV_LO): if (latch_open) rdata <= divisor[DATA_W-1:0];
          WORD_W'(OFS_DIV_HI): if (latch_open) rdata <= divisor[2*DATA_W-1:DATA_W];
          WORD_W'(OFS_LINE):   rdata <= line_ctl;
          WORD_W'(OFS_SPEED):  rdata <= {{(DATA_W-2){1'b0}}, speed};
          WORD_W'(OFS_COUNT):  rdata <= count;
          WORD_W'(OFS_POINT):  rdata <= point;
          WORD_W'(OFS_FIX):    rdata <= {{(DATA_W-1){1'b0}}, fix_bit};
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/urg_ratio.sv
module urg_ratio
  import uart_rate_pkg::*;
#(
  parameter int SC_W = 8
) (
  input  logic [1:0]      speed,
  input  logic [SC_W-1:0] count,
  input  logic [SC_W-1:0] point,
  output logic [SC_W:0]   ratio,
  output logic [SC_W-1:0] pos
);

  localparam int RW = SC_W + 1;

  logic [RW-1:0] mid;
  logic          prog_ok;

  always_comb begin
    case (speed_mode_e'(speed))
      SPD_QUAD: ratio = RW'(4);
      SPD_PROG: ratio = {1'b0, count} + RW'(1);
      default:  ratio = RW'(16);
    endcase

    if (ratio < RW'(2)) mid = '0;
    else                mid = (ratio - RW'(2)) >> 1;

    prog_ok = (speed_mode_e'(speed) == SPD_PROG) && (point != '1) &&
              ({1'b0, point} < ratio);
    pos = prog_ok ? point : mid[SC_W-1:0];
  end

endmodule

// File: rtl/urg_timer.sv
module urg_timer #(
  parameter int DIV_W = 16,
  parameter int SC_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_in,
  input  logic [DIV_W-1:0] new_div,
  input  logic [SC_W:0]    new_ratio,
  input  logic [SC_W-1:0]  new_pos,
  output logic [DIV_W-1:0] act_div,
  output logic             os_tick,
  output logic             bit_tick,
  output logic             sample_strobe,
  output logic             sample_bit
);

  localparam int RW = SC_W + 1;

  logic [RW-1:0]    act_ratio;
  logic [SC_W-1:0]  act_pos;
  logic [DIV_W-1:0] pre_cnt;
  logic [RW-1:0]    tick_idx;
  logic [1:0]       rx_sync;
  logic             rx_prev;
  logic             hunting;

  logic fall, stopped, os_c, last_c, strobe_c, load;

  always_comb begin
    stopped  = (act_div == '0);
    fall     = hunting && rx_prev && !rx_sync[1];
    os_c     = !stopped && (pre_cnt == act_div - DIV_W'(1)) && !fall;
    last_c   = os_c && (tick_idx == act_ratio - RW'(1));
    strobe_c = os_c && (tick_idx == {1'b0, act_pos});
    load     = last_c || fall || stopped;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sync <= 2'b11;
      rx_prev <= 1'b1;
      hunting <= 1'b1;
    end else begin
      rx_sync <= {rx_sync[0], rx_in};
      rx_prev <= rx_sync[1];
      if (fall)                         hunting <= 1'b0;
      else if (strobe_c && rx_sync[1])  hunting <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_div   <= '0;
      act_ratio <= RW'(16);
      act_pos   <= SC_W'(7);
    end else if (load) begin
      act_div   <= new_div;
      act_ratio <= new_ratio;
      act_pos   <= new_pos;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt  <= '0;
      tick_idx <= '0;
    end else if (fall || stopped) begin
      pre_cnt  <= '0;
      tick_idx <= '0;
    end else if (os_c) begin
      pre_cnt  <= '0;
      tick_idx <= last_c ? '0 : tick_idx + RW'(1);
    end else begin
      pre_cnt  <= pre_cnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      os_tick       <= 1'b0;
      bit_tick      <= 1'b0;
      sample_strobe <= 1'b0;
      sample_bit    <= 1'b1;
    end else begin
      os_tick       <= os_c;
      bit_tick      <= last_c;
      sample_strobe <= strobe_c;
      if (strobe_c) sample_bit <= rx_sync[1];
    end
  end

endmodule

// File: rtl/uart_rate_gen.sv
module uart_rate_gen #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              rx_in,
  output logic              os_tick,
  output logic              bit_tick,
  output logic              sample_strobe,
  output logic              sample_bit
);

  localparam int DIV_W = 2 * DATA_W;
  localparam int SC_W  = DATA_W;

  logic [DIV_W-1:0] prog_div;
  logic [1:0]       prog_speed;
  logic [SC_W-1:0]  prog_count;
  logic [SC_W-1:0]  prog_point;
  logic [SC_W:0]    next_ratio;
  logic [SC_W-1:0]  next_pos;
  logic [DIV_W-1:0] act_div_w;

  urg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .divisor(prog_div), .speed(prog_speed),
    .count(prog_count), .point(prog_point)
  );

  urg_ratio #(.SC_W(SC_W)) u_ratio (
    .speed(prog_speed), .count(prog_count), .point(prog_point),
    .ratio(next_ratio), .pos(next_pos)
  );

  urg_timer #(.DIV_W(DIV_W), .SC_W(SC_W)) u_timer (
    .clk(clk), .rst(rst), .rx_in(rx_in), .new_div(prog_div),
    .new_ratio(next_ratio), .new_pos(next_pos), .act_div(act_div_w),
    .os_tick(os_tick), .bit_tick(bit_tick), .sample_strobe(sample_strobe),
    .sample_bit(sample_bit)
  );

endmodule

// File: rtl/uart_rate_gen_chk.sv
module uart_rate_gen_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             os_tick,
  input logic             bit_tick,
  input logic             sample_strobe,
  input logic             sample_bit,
  input logic [DIV_W-1:0] act_div
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!os_tick && !bit_tick && !sample_strobe)); // R1

  AST_DIV_ZERO_SILENT: assert property (@(posedge clk) disable iff (rst)
    (act_div == '0) |=> !os_tick); // R4

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    os_tick |=> (!os_tick || $past(act_div) == DIV_W'(1))); // R4

  AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    sample_strobe |-> os_tick); // R8

  AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sample_strobe |-> $stable(sample_bit)); // R9

  AST_BOUNDARY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> os_tick); // R13

endmodule

bind uart_rate_gen uart_rate_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .os_tick(os_tick), .bit_tick(bit_tick),
  .sample_strobe(sample_strobe), .sample_bit(sample_bit), .act_div(act_div_w)
);

// File: tb/uart_rate_gen_tb.sv
`timescale 1ns/1ps
module uart_rate_gen_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rx = 1'b1;
  logic       os_tick, bit_tick, sample_strobe, sample_bit;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  uart_rate_gen u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rx_in(rx), .os_tick(os_tick),
    .bit_tick(bit_tick), .sample_strobe(sample_strobe), .sample_bit(sample_bit)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected below 190000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int word, int data);
    @(negedge clk);
    wr_en = 1'b1; addr = 6'(word << 2); wdata = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int word, output int data);
    @(negedge clk);
    rd_en = 1'b1; addr = 6'(word << 2);
    @(negedge clk);
    rd_en = 1'b0;
    data = int'(rdata);
  endtask

  function automatic int exp_ratio(int mode, int cnt);
    if (mode == 2) return 4;
    if (mode == 3) return cnt + 1;
    return 16;
  endfunction

  function automatic int exp_pos(int mode, int cnt, int pt);
    int r = exp_ratio(mode, cnt);
    if (mode == 3 && pt != 255 && pt < r) return pt;
    if (r < 2) return 0;
    return (r - 2) >> 1;
  endfunction

  task automatic wait_bits(int n);
    for (int i = 0; i < n; i++) begin
      int lim = 0;
      do begin @(negedge clk); lim++; end while (!bit_tick && lim < 20000);
    end
  endtask

  task automatic setcfg(int div, int mode, int cnt, int pt);
    wr(3, 8'h80);
    wr(0, div & 8'hFF);
    wr(1, div >> 8);
    wr(3, 8'h03);
    wr(9, mode);
    wr(10, cnt);
    wr(11, pt);
    wait_bits(2);
  endtask

  task automatic measure(string req, int div, int ratio, int pos);
    int c = 0, nos = 0, spos = -1, lim = 0;
    while (!bit_tick && lim < 20000) begin @(negedge clk); lim++; end
    do begin
      @(negedge clk); c++;
      if (os_tick) nos++;
      if (sample_strobe && spos < 0) spos = c;
    end while (!bit_tick && c < 20000);
    chk(req, "bit period cycles", c, ratio * div);
    chk(req, "ticks per bit", nos, ratio);
    chk("R8", "strobe offset", spos, (pos + 1) * div);
  endtask

  initial begin
    int v;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(3, v);  chk("R1", "line control", v, 0);
    rd(9, v);  chk("R1", "speed mode", v, 0);
    rd(10, v); chk("R1", "tick count", v, 0);
    rd(11, v); chk("R1", "capture point", v, 255);
    rd(13, v); chk("R1", "rate fix", v, 0);
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        seen += int'(os_tick) + int'(bit_tick) + int'(sample_strobe);
      end
      chk("R4", "pulses with zero divisor", seen, 0);
    end

    // divisor latch gating
    rd(0, v); chk("R3", "div low read with latch closed", v, 0);
    wr(0, 8'h55);
    wr(3, 8'h80);
    rd(0, v); chk("R3", "div low after closed write", v, 0);
    rd(1, v); chk("R1", "div high reset", v, 0);
    wr(0, 8'h3C);
    rd(0, v); chk("R3", "div low with latch open", v, 8'h3C);
    wr(0, 0);
    wr(3, 0);

    // misaligned access and rate fix storage
    @(negedge clk); wr_en = 1'b1; addr = 6'h25; wdata = 8'h02;
    @(negedge clk); wr_en = 1'b0;
    rd(9, v); chk("R2", "misaligned write dropped", v, 0);
    wr(13, 1);
    rd(13, v); chk("R12", "rate fix readback", v, 1);
    wr(13, 0);
    wr(10, 8'h21);
    rd(10, v); chk("R2", "tick count readback", v, 8'h21);

    // directed timing cases
    setcfg(3, 0, 0, 255);   measure("R5", 3, 16, 7);
    setcfg(2, 1, 0, 255);   measure("R5", 2, 16, 7);
    setcfg(5, 2, 0, 255);   measure("R6", 5, 4, 1);
    wr(13, 1);
    wait_bits(2);           measure("R12", 5, 4, 1);
    wr(13, 0);
    setcfg(2, 3, 15, 255);  measure("R7", 2, 16, 7);
    setcfg(1, 3, 9, 3);     measure("R7", 1, 10, 3);
    setcfg(3, 3, 0, 255);   measure("R7", 3, 1, 0);
    setcfg(2, 3, 4, 9);     measure("R8", 2, 5, 1);
    setcfg(1, 3, 255, 255); measure("R7", 1, 256, 127);

    // change in the middle of a period
    setcfg(2, 0, 0, 255);
    begin
      int c = 0, lim = 0;
      while (!bit_tick && lim < 20000) begin @(negedge clk); lim++; end
      do begin
        @(negedge clk); c++;
        if (c == 3) begin wr_en = 1'b1; addr = 6'(9 << 2); wdata = 8'd2; end
        if (c == 4) wr_en = 1'b0;
      end while (!bit_tick && c < 20000);
      chk("R11", "period during change", c, 32);
    end
    measure("R11", 2, 4, 1);

    // start-bit alignment
    setcfg(2, 0, 0, 255);
    measure("R5", 2, 16, 7);
    begin
      int nstrobe = 0, nbit = 0;
      @(negedge clk);
      rx = 1'b0;
      for (int k = 1; k <= 90; k++) begin
        @(negedge clk);
        if (k == 22) rx = 1'b1;
        if (k == 25) rx = 1'b0;
        if (k == 55) rx = 1'b1;
        if (k >= 3) begin
          nstrobe += int'(sample_strobe);
          nbit    += int'(bit_tick);
        end
        if (k == 19) begin
          chk("R10", "first strobe after start edge", int'(sample_strobe), 1);
          chk("R9", "start bit captured", int'(sample_bit), 0);
        end
        if (k == 35) chk("R10", "first boundary after start edge", int'(bit_tick), 1);
        if (k == 51) begin
          chk("R10", "strobe unmoved by edge while not hunting", int'(sample_strobe), 1);
          chk("R9", "low level captured", int'(sample_bit), 0);
        end
        if (k == 83) begin
          chk("R9", "strobe at third bit", int'(sample_strobe), 1);
          chk("R9", "high level captured", int'(sample_bit), 1);
        end
      end
      chk("R10", "strobes after alignment", nstrobe, 3);
      chk("R13", "boundaries after alignment", nbit, 2);
    end

    // constrained random configurations
    for (int it = 0; it < 12; it++) begin
      int mode, div, cnt, pt, r, sel;
      mode = int'($urandom % 4);
      div  = 1 + int'($urandom % 6);
      cnt  = int'($urandom % 32);
      r    = exp_ratio(mode, cnt);
      sel  = int'($urandom % 3);
      if (sel == 0)      pt = 255;
      else if (sel == 1) pt = int'($urandom % r);
      else               pt = r + int'($urandom % 8);
      if (pt > 254 && sel != 0) pt = 254;
      setcfg(div, mode, cnt, pt);
      measure((mode == 3) ? "R7" : ((mode == 2) ? "R6" : "R5"),
              div, r, exp_pos(mode, cnt, pt));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule